// File: doc/BRIEF.md
# Paged Memory Window Mapper

The mapper divides a 64 KB processor address space into four 16 KB windows and places each window onto one of sixteen 16 KB RAM blocks or onto a single boot-ROM block. For every processor access it reports three things. The first is the physical block number (5 bits). The second is whether that block is mapped at all. The third is the 14-bit byte offset inside the block. It also raises a select line when the access is served by the boot ROM. All of these outputs are combinational from the address, the access direction and two pieces of registered state.

The first piece of state is a 3-bit layout code, loaded by a write to the layout port. It chooses one of eight fixed, irregular arrangements for the lower three windows. The highest window never moves. The second piece of state is the boot overlay flag. It is set by reset and is cleared for good by any write to the overlay-release port. While the overlay is active, reads from the lowest window return the ROM block, but writes to that window still land in RAM. Once the overlay is released, reads and writes of the lowest window follow the same layout.

Top module: `page_window_mapper`

## Requirements
- R1: After reset the layout code is 0 and the overlay is active. A read of window 0 gives block 16 with romSel=1. A write to window 0 gives block 1. Windows 1 and 2 give blocks 2 and 3.
- R2: Window 3 (cpuAddr[15:14]=3) always gives block 0 with blockValid=1 and romSel=0, whatever the code, overlay state or direction.
- R3: Only bankData[2:0] is loaded as the layout code; bits 7..3 have no effect.
- R4: For codes n = 0..4, windows 0, 1 and 2 give blocks 3n+1, 3n+2 and 3n+3.
- R5: Code 5 gives blocks 1, 2 and 13 for windows 0, 1 and 2; code 7 gives blocks 1, 4 and 13.
- R6: Code 6 gives blocks 14 and 15 for windows 0 and 1. Window 2 is unmapped: blockValid=0 and blockNum=0.
- R7: While the overlay is active, a layout write changes only the write mapping of window 0; reads of window 0 stay on block 16 with romSel=1.
- R8: A romOffWe strobe, whatever the data, releases the overlay at that clock edge. Window-0 reads then follow the current layout with romSel=0. The release lasts until the next reset, and later layout writes move reads and writes together.
- R9: blockOffset equals cpuAddr[13:0] for every access, in the same cycle.
- R10: A layout write strobed in one cycle changes the outputs only after the next rising clock edge; before that edge the old mapping is still shown.
- R11: A layout write and an overlay release strobed in the same cycle both take effect at the same edge, so window-0 reads immediately follow the new layout.
- R12: romSel=1 only for a read of window 0 with the overlay active, and then blockNum=16 and blockValid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| bankWe | input | 1 | Layout-port write strobe |
| bankData | input | 8 | Layout-port write data (low 3 bits used) |
| romOffWe | input | 1 | Overlay-release port write strobe |
| cpuAddr | input | 16 | Processor address |
| cpuWrite | input | 1 | 1 = write access, 0 = read access |
| blockNum | output | 5 | Physical block number (16 = boot ROM) |
| blockValid | output | 1 | Access falls on a mapped block |
| blockOffset | output | 14 | Byte offset within the block |
| romSel | output | 1 | Access is served by the boot ROM |

## Verification
Two events can land on the same edge: a layout load and an overlay release. The bench provokes this by raising bankWe and romOffWe in one cycle after a fresh reset, with code 6, which moves window 0 away from block 1. It then checks that the very next window-0 read reports block 14 from RAM, not ROM block 16 and not the reset block 1. The same sequence with only one strobe raised shows which event alone produced which change.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int ADDR_W    = 16;
  localparam int WIN_SEL_W = 2;
  localparam int BLK_W     = 5;
  localparam int CODE_W    = 3;
  localparam int PORT_W    = 8;
  localparam int ROM_BLK   = 16;
  localparam int FIXED_BLK = 0;
  localparam int OFFS_W    = ADDR_W - WIN_SEL_W;
  localparam int NUM_WIN   = 1 << WIN_SEL_W;

  typedef struct packed {
    logic loadCode;
    logic overlayOn;
  } mapCtrl_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
#(
  parameter int P_PORT_W = PORT_W,
  parameter int P_CODE_W = CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bankWe,
  input  logic [P_PORT_W-1:0] bankData,
  input  logic                romOffWe,
  output mapCtrl_t            ctrl,
  output logic [P_CODE_W-1:0] newCode
);
  logic romOn;
  logic unusedHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) romOn <= 1'b1;
    else if (romOffWe) romOn <= 1'b0;
  end

  assign newCode       = bankData[P_CODE_W-1:0];
  assign unusedHigh    = ^bankData[P_PORT_W-1:P_CODE_W];
  assign ctrl.loadCode  = bankWe;
  assign ctrl.overlayOn = romOn;
endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import mapper_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_WIN_W  = WIN_SEL_W,
  parameter int P_BLK_W  = BLK_W,
  parameter int P_CODE_W = CODE_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  mapCtrl_t                     ctrl,
  input  logic [P_CODE_W-1:0]          newCode,
  input  logic [P_ADDR_W-1:0]          cpuAddr,
  input  logic                         cpuWrite,
  output logic [P_BLK_W-1:0]           blockNum,
  output logic                         blockValid,
  output logic [P_ADDR_W-P_WIN_W-1:0]  blockOffset,
  output logic                         romSel
);
  localparam int L_WINS = 1 << P_WIN_W;
  localparam int L_OFFS = P_ADDR_W - P_WIN_W;

  logic [P_CODE_W-1:0] codeQ;
  logic [P_BLK_W-1:0]  winBlk [L_WINS];
  logic                winOk  [L_WINS];
  logic [P_WIN_W-1:0]  winSel;
  logic                romHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeQ <= '0;
    else if (ctrl.loadCode) codeQ <= newCode;
  end

  // Returns {mapped, block} for one window under one layout code.
  function automatic logic [P_BLK_W:0] layoutEntry(input logic [P_CODE_W-1:0] c, input int w);
    int blk;
    logic ok;
    ok = 1'b1;
    if (w == L_WINS - 1) blk = FIXED_BLK;
    else begin
      case (int'(c))
        5:       blk = (w == 0) ? 1 : ((w == 1) ? 2 : 13);
        6: begin
          blk = 14 + w;
          if (w == 2) begin blk = 0; ok = 1'b0; end
        end
        7:       blk = (w == 0) ? 1 : ((w == 1) ? 4 : 13);
        default: blk = 3 * int'(c) + 1 + w;
      endcase
    end
    return {ok, P_BLK_W'(blk)};
  endfunction

  for (genvar gw = 0; gw < L_WINS; gw++) begin : g_win
    always_comb begin
      logic [P_BLK_W:0] ent;
      ent = layoutEntry(codeQ, gw);
      winOk[gw]  = ent[P_BLK_W];
      winBlk[gw] = ent[P_BLK_W-1:0];
    end
  end

  assign winSel      = cpuAddr[P_ADDR_W-1 -: P_WIN_W];
  assign romHit      = ctrl.overlayOn && !cpuWrite && (winSel == '0);
  assign blockOffset = cpuAddr[L_OFFS-1:0];

  always_comb begin
    if (romHit) begin
      blockNum   = P_BLK_W'(ROM_BLK);
      blockValid = 1'b1;
    end else begin
      blockValid = winOk[winSel];
      blockNum   = winOk[winSel] ? winBlk[winSel] : '0;
    end
  end
  assign romSel = romHit;
endmodule

// File: rtl/page_window_mapper.sv
module page_window_mapper
  import mapper_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                bankWe,
  input  logic [PORT_W-1:0]   bankData,
  input  logic                romOffWe,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                cpuWrite,
  output logic [BLK_W-1:0]    blockNum,
  output logic                blockValid,
  output logic [OFFS_W-1:0]   blockOffset,
  output logic                romSel
);
  mapCtrl_t            ctrl;
  logic [CODE_W-1:0]   newCode;

  mapper_ctrl #(.P_PORT_W(PORT_W), .P_CODE_W(CODE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .bankWe(bankWe), .bankData(bankData),
    .romOffWe(romOffWe), .ctrl(ctrl), .newCode(newCode)
  );

  mapper_datapath #(.P_ADDR_W(ADDR_W), .P_WIN_W(WIN_SEL_W), .P_BLK_W(BLK_W),
                    .P_CODE_W(CODE_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .newCode(newCode),
    .cpuAddr(cpuAddr), .cpuWrite(cpuWrite), .blockNum(blockNum),
    .blockValid(blockValid), .blockOffset(blockOffset), .romSel(romSel)
  );
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker
  import mapper_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 romOffWe,
  input logic [WIN_SEL_W-1:0] cpuWin,
  input logic                 cpuWrite,
  input logic [BLK_W-1:0]     blockNum,
  input logic                 blockValid,
  input logic                 romSel
);
  logic romGone;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) romGone <= 1'b0;
    else if (romOffWe) romGone <= 1'b1;
  end

  assert_top_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWin == WIN_SEL_W'(NUM_WIN - 1)) |-> (blockValid && blockNum == BLK_W'(FIXED_BLK) && !romSel));

  assert_rom_only_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> (!cpuWrite && cpuWin == '0 && blockNum == BLK_W'(ROM_BLK) && blockValid));

  assert_overlay_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!romGone && !cpuWrite && cpuWin == '0) |-> romSel);

  assert_release_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    romGone |-> !romSel);

  assert_unmapped_R6: assert property (@(posedge clk) disable iff (!rstN)
    !blockValid |-> (blockNum == '0 && cpuWin == WIN_SEL_W'(2)));
endmodule

bind page_window_mapper mapper_checker i_mapper_checker (
  .clk(clk), .rstN(rstN), .romOffWe(romOffWe),
  .cpuWin(cpuAddr[mapper_pkg::ADDR_W-1 -: mapper_pkg::WIN_SEL_W]),
  .cpuWrite(cpuWrite), .blockNum(blockNum), .blockValid(blockValid), .romSel(romSel)
);

// File: tb/test_page_window_mapper.sv
module test_page_window_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bankWe = 1'b0;
  logic [7:0]  bankData = '0;
  logic        romOffWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuWrite = 1'b0;
  logic [4:0]  blockNum;
  logic        blockValid;
  logic [13:0] blockOffset;
  logic        romSel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  page_window_mapper i_page_window_mapper (
    .clk(clk), .rstN(rstN), .bankWe(bankWe), .bankData(bankData),
    .romOffWe(romOffWe), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .blockNum(blockNum), .blockValid(blockValid),
    .blockOffset(blockOffset), .romSel(romSel)
  );

  always #10 clk = ~clk;

  // Expected block from the layout table in the requirements; -1 = unmapped.
  function automatic int refBlk(int code, int w);
    if (w == 3) return 0;
    case (code)
      5: return (w == 0) ? 1 : ((w == 1) ? 2 : 13);
      6: return (w == 2) ? -1 : 14 + w;
      7: return (w == 0) ? 1 : ((w == 1) ? 4 : 13);
      default: return 3 * code + 1 + w;
    endcase
  endfunction

  task automatic probe(input logic [15:0] a, input logic wr, input int expBlk,
                       input logic expRom, input string req);
    logic [4:0] eb;
    logic       ev;
    @(negedge clk);
    cpuAddr = a; cpuWrite = wr;
    #2;
    ev = (expBlk >= 0);
    eb = ev ? 5'(expBlk) : 5'd0;
    checks++;
    if (blockNum !== eb || blockValid !== ev || romSel !== expRom || blockOffset !== a[13:0]) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b: got blk=%0d v=%0b rom=%0b off=%h, want blk=%0d v=%0b rom=%0b off=%h",
               req, a, wr, blockNum, blockValid, romSel, blockOffset, eb, ev, expRom, a[13:0]);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeBank(input logic [7:0] d);
    @(negedge clk); bankWe = 1'b1; bankData = d;
    @(negedge clk); bankWe = 1'b0;
  endtask

  task automatic releaseRom(input logic [7:0] d);
    @(negedge clk); romOffWe = 1'b1; bankData = d;
    @(negedge clk); romOffWe = 1'b0;
  endtask

  task automatic testReset();   // R1
    doReset();
    probe(16'h0123, 1'b0, 16, 1'b1, "R1 rd w0");
    probe(16'h0123, 1'b1, 1, 1'b0, "R1 wr w0");
    probe(16'h4abc, 1'b0, 2, 1'b0, "R1 w1");
    probe(16'hbfff, 1'b1, 3, 1'b0, "R1 w2");
  endtask

  task automatic testLayoutsOverlay();   // R4 R5 R6 R7 R2
    doReset();
    for (int c = 0; c < 8; c++) begin
      writeBank(8'(c));
      probe(16'h0010, 1'b1, refBlk(c, 0), 1'b0, (c < 5) ? "R4 w0" : "R5/R6 w0");
      probe(16'h5555, 1'b0, refBlk(c, 1), 1'b0, (c < 5) ? "R4 w1" : "R5/R6 w1");
      probe(16'h8001, 1'b1, refBlk(c, 2), 1'b0, (c == 6) ? "R6 w2" : "R4/R5 w2");
      probe(16'h3ffe, 1'b0, 16, 1'b1, "R7 rd w0 stays ROM");
      probe(16'hc000 + 16'(c), 1'b0, 0, 1'b0, "R2 rd w3");
      probe(16'hffff, 1'b1, 0, 1'b0, "R2 wr w3");
    end
  endtask

  task automatic testMask();   // R3
    doReset();
    writeBank(8'hfd);   // low bits 101 -> code 5
    probe(16'h8000, 1'b0, 13, 1'b0, "R3 upper bits ignored w2");
    probe(16'h4000, 1'b0, 2, 1'b0, "R3 upper bits ignored w1");
  endtask

  task automatic testTiming();   // R10 R9
    doReset();
    @(negedge clk); bankWe = 1'b1; bankData = 8'd2;
    cpuAddr = 16'h4321; cpuWrite = 1'b0; #2;
    checks++;
    if (blockNum !== 5'd2) begin fails++; $display("FAIL R10 before edge got %0d want 2", blockNum); end
    @(posedge clk); #2;
    checks++;
    if (blockNum !== 5'd8) begin fails++; $display("FAIL R10 after edge got %0d want 8", blockNum); end
    checks++;
    if (blockOffset !== 14'h0321) begin fails++; $display("FAIL R9 off got %h want 0321", blockOffset); end
    @(negedge clk); bankWe = 1'b0;
    probe(16'h7abc, 1'b1, 8, 1'b0, "R9 offset w1");
  endtask

  task automatic testRelease();   // R8
    doReset();
    writeBank(8'd3);
    releaseRom(8'h00);
    probe(16'h0042, 1'b0, 10, 1'b0, "R8 rd w0 after release");
    writeBank(8'd7);
    probe(16'h0042, 1'b0, 1, 1'b0, "R8 rd follows layout");
    probe(16'h4042, 1'b0, 4, 1'b0, "R8 w1 layout 7");
    writeBank(8'd4);
    probe(16'h0000, 1'b0, 13, 1'b0, "R8 sticky rd");
    probe(16'h0000, 1'b1, 13, 1'b0, "R8 sticky wr");
    doReset();
    probe(16'h0000, 1'b0, 16, 1'b1, "R8 reset restores overlay");
  endtask

  task automatic testSameCycle();   // R11
    doReset();
    @(negedge clk); bankWe = 1'b1; romOffWe = 1'b1; bankData = 8'd6;
    @(negedge clk); bankWe = 1'b0; romOffWe = 1'b0;
    probe(16'h1000, 1'b0, 14, 1'b0, "R11 rd w0 both strobes");
    probe(16'h9000, 1'b0, -1, 1'b0, "R11 w2 unmapped");
  endtask

  initial begin
    testReset();
    testLayoutsOverlay();
    testMask();
    testTiming();
    testRelease();
    testSameCycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule